// File: doc/BRIEF.md
# Pseudo-associative cache lookup controller

This block is the lookup and probe sequencer of a small direct-mapped cache that offers every index a second chance. A read first checks the frame its own index selects. If that frame does not hold the line, the controller checks a partner frame whose index differs only in the top bit. If neither holds it, the controller fetches one block over a simple memory handshake. The two frames that share all lower index bits form a pseudo-set. The controller keeps the most recently used line of each pseudo-set in the frame the line's own index selects.

The CPU side takes one request at a time through a valid/ready pair. It returns a one-cycle response that carries the read data and an outcome code. The memory side uses a request that is held until acknowledged, and it serves both fills and write-through stores. Stores update a resident line in place and always go on to memory. A store that misses allocates nothing. A block is one data word.

Top module: `pac_cache_ctrl`

## Requirements
- R1: After reset, req_ready is high and rsp_valid and mem_req_valid are low. Every frame is invalid, so the first read of any address misses.
- R2: The address splits into three fields. The low OFF_W = log2(DATA_W/8) bits are the byte offset. The next IDX_W bits are the index. The remaining upper bits are the tag. Addresses that differ only in the offset refer to the same block.
- R3: rsp_kind is 1 for a primary hit, 2 for a pseudo-hit and 3 for a miss. Let E be the clock edge at which a read is accepted. A primary read hit raises rsp_valid after edge E+1, and a pseudo-hit raises it after edge E+2. Neither of them issues a memory request.
- R4: The partner frame of index i is i with its most significant bit inverted. A line that sits in the partner frame is found as a pseudo-hit.
- R5: On a read pseudo-hit the two frames of the pseudo-set swap contents. An immediate repeat of the same read is then a primary hit, and the line that was displaced becomes a pseudo-hit.
- R6: On a read miss the fetched block is written into the primary frame. The line previously in the primary frame moves to the partner frame. The line previously in the partner frame is dropped.
- R7: A frame hits only when its valid bit is set and its stored tag equals the request tag extended with the request's index MSB. Two addresses that differ only in the index MSB are therefore distinct lines.
- R8: Every store issues one memory write with the request address and data. The response (kind 1, 2 or 3) follows the edge at which mem_ack is seen. A store hit updates the cached word in place without swapping, so a later read returns the new data without a memory request. A store miss leaves the cache unchanged.
- R9: Only one request is outstanding at a time. req_ready is low from the edge after acceptance until the response cycle has ended. req_valid is ignored while req_ready is low. rsp_valid lasts exactly one cycle.
- R10: On a read miss, mem_req_valid rises after edge E+2 and holds address and direction stable until the edge that samples mem_ack. The response follows that edge and returns mem_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 for a store, 0 for a read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_kind | output | 2 | Outcome: 1 primary hit, 2 pseudo-hit, 3 miss |
| rsp_rdata | output | DATA_W | Read data |
| mem_req_valid | output | 1 | Memory transfer requested, held until acknowledged |
| mem_req_write | output | 1 | 1 for a write-through store, 0 for a fill |
| mem_req_addr | output | ADDR_W | Memory address |
| mem_req_wdata | output | DATA_W | Store data for memory |
| mem_ack | input | 1 | Memory completes the transfer in this cycle |
| mem_rdata | input | DATA_W | Fill data, valid with mem_ack |

## Verification
A read that hits the primary frame answers one edge after acceptance, and a pseudo-hit answers two edges after it. Every other outcome answers on the edge after the one that samples mem_ack. With the bench memory model that edge falls four edges after acceptance for a fill or for a store that missed the primary frame, and three edges after it for a store that hit the primary frame. The bench drives each request on a falling edge and then counts falling edges until rsp_valid is seen. It compares that count with the latency listed for the vector, which is set by the kind and direction of the access. On the same falling edge it reads kind and data, and it compares the number of memory transfers made during the request with the number expected.

// File: rtl/pac_pkg.sv
package pac_pkg;

  typedef enum logic [1:0] {
    KIND_NONE    = 2'd0,
    KIND_PRIMARY = 2'd1,
    KIND_PSEUDO  = 2'd2,
    KIND_MISS    = 2'd3
  } pac_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRI  = 3'd1,
    ST_ALT  = 3'd2,
    ST_FILL = 3'd3,
    ST_WMEM = 3'd4,
    ST_RSP  = 3'd5
  } pac_state_e;

endpackage

// File: rtl/pac_rst_sync.sv
module pac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pac_frame_store.sv
module pac_frame_store #(
  parameter int IDX_W  = 3,
  parameter int LT_W   = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic              rd_a_vld,
  output logic [LT_W-1:0]   rd_a_tag,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic              rd_b_vld,
  output logic [LT_W-1:0]   rd_b_tag,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_a_en,
  input  logic [IDX_W-1:0]  wr_a_idx,
  input  logic              wr_a_vld,
  input  logic [LT_W-1:0]   wr_a_tag,
  input  logic [DATA_W-1:0] wr_a_data,
  input  logic              wr_b_en,
  input  logic [IDX_W-1:0]  wr_b_idx,
  input  logic              wr_b_vld,
  input  logic [LT_W-1:0]   wr_b_tag,
  input  logic [DATA_W-1:0] wr_b_data
);

  localparam int FRAMES = 1 << IDX_W;

  logic [FRAMES-1:0] vld_vec;
  logic [LT_W-1:0]   tag_arr  [FRAMES];
  logic [DATA_W-1:0] data_arr [FRAMES];

  for (genvar g = 0; g < FRAMES; g++) begin : g_frame
    logic              sel_a;
    logic              sel_b;
    logic              vld_q;
    logic [LT_W-1:0]   tag_q;
    logic [DATA_W-1:0] data_q;

    assign sel_a = wr_a_en && (wr_a_idx == IDX_W'(g));
    assign sel_b = wr_b_en && (wr_b_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q <= 1'b0;
      else if (sel_a) vld_q <= wr_a_vld;
      else if (sel_b) vld_q <= wr_b_vld;
    end

    always_ff @(posedge clk) begin
      if (sel_a) begin
        tag_q  <= wr_a_tag;
        data_q <= wr_a_data;
      end else if (sel_b) begin
        tag_q  <= wr_b_tag;
        data_q <= wr_b_data;
      end
    end

    assign vld_vec[g]  = vld_q;
    assign tag_arr[g]  = tag_q;
    assign data_arr[g] = data_q;
  end

  assign rd_a_vld  = vld_vec[rd_a_idx];
  assign rd_a_tag  = tag_arr[rd_a_idx];
  assign rd_a_data = data_arr[rd_a_idx];
  assign rd_b_vld  = vld_vec[rd_b_idx];
  assign rd_b_tag  = tag_arr[rd_b_idx];
  assign rd_b_data = data_arr[rd_b_idx];

endmodule

// File: rtl/pac_tag_match.sv
module pac_tag_match #(
  parameter int LT_W = 12
) (
  input  logic            line_vld,
  input  logic [LT_W-1:0] line_tag,
  input  logic [LT_W-1:0] probe_tag,
  output logic            hit
);

  assign hit = line_vld && (line_tag == probe_tag);

endmodule

// File: rtl/pac_probe_seq.sv
module pac_probe_seq
  import pac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2,
  parameter int TAG_W  = 11,
  parameter int LT_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  prim_idx,
  output logic [IDX_W-1:0]  alt_idx,
  output logic [LT_W-1:0]   probe_tag,
  input  logic              hit_a,
  input  logic              hit_b,
  input  logic              a_vld,
  input  logic [LT_W-1:0]   a_tag,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_vld,
  input  logic [LT_W-1:0]   b_tag,
  input  logic [DATA_W-1:0] b_data,
  output logic              wa_en,
  output logic              wa_vld,
  output logic [LT_W-1:0]   wa_tag,
  output logic [DATA_W-1:0] wa_data,
  output logic              wb_en,
  output logic              wb_vld,
  output logic [LT_W-1:0]   wb_tag,
  output logic [DATA_W-1:0] wb_data
);

  localparam logic [IDX_W-1:0] MSB_MASK = IDX_W'(1) << (IDX_W - 1);

  pac_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  pac_kind_e         kind_q, kind_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              cap_en;

  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;

  assign cur_idx   = addr_q[OFF_W +: IDX_W];
  assign cur_tag   = addr_q[ADDR_W-1 -: TAG_W];
  assign prim_idx  = cur_idx;
  assign alt_idx   = cur_idx ^ MSB_MASK;
  assign probe_tag = {cur_tag, cur_idx[IDX_W-1]};

  assign cap_en = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    rdata_d = rdata_q;
    wa_en   = 1'b0;
    wa_vld  = 1'b0;
    wa_tag  = probe_tag;
    wa_data = wdata_q;
    wb_en   = 1'b0;
    wb_vld  = 1'b0;
    wb_tag  = probe_tag;
    wb_data = wdata_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) state_d = ST_PRI;
      end
      ST_PRI: begin
        if (hit_a) begin
          kind_d = KIND_PRIMARY;
          if (wr_q) begin
            wa_en   = 1'b1;
            wa_vld  = 1'b1;
            state_d = ST_WMEM;
          end else begin
            rdata_d = a_data;
            state_d = ST_RSP;
          end
        end else begin
          state_d = ST_ALT;
        end
      end
      ST_ALT: begin
        if (hit_b) begin
          kind_d = KIND_PSEUDO;
          if (wr_q) begin
            wb_en   = 1'b1;
            wb_vld  = 1'b1;
            state_d = ST_WMEM;
          end else begin
            rdata_d = b_data;
            wa_en   = 1'b1;
            wa_vld  = b_vld;
            wa_tag  = b_tag;
            wa_data = b_data;
            wb_en   = 1'b1;
            wb_vld  = a_vld;
            wb_tag  = a_tag;
            wb_data = a_data;
            state_d = ST_RSP;
          end
        end else begin
          kind_d  = KIND_MISS;
          state_d = wr_q ? ST_WMEM : ST_FILL;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          wa_en   = 1'b1;
          wa_vld  = 1'b1;
          wa_data = mem_rdata;
          wb_en   = 1'b1;
          wb_vld  = a_vld;
          wb_tag  = a_tag;
          wb_data = a_data;
          rdata_d = mem_rdata;
          state_d = ST_RSP;
        end
      end
      ST_WMEM: begin
        if (mem_ack) state_d = ST_RSP;
      end
      ST_RSP: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q  <= req_addr;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    kind_q  <= kind_d;
    rdata_q <= rdata_d;
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RSP);
  assign rsp_kind      = kind_q;
  assign rsp_rdata     = rdata_q;
  assign mem_req_valid = (state_q == ST_FILL) || (state_q == ST_WMEM);
  assign mem_req_write = (state_q == ST_WMEM);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

endmodule

// File: rtl/pac_cache_ctrl.sv
module pac_cache_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int LT_W  = TAG_W + 1;

  logic              rst_sync_n;
  logic [IDX_W-1:0]  prim_idx, alt_idx;
  logic [LT_W-1:0]   probe_tag;
  logic              a_vld, b_vld, hit_a, hit_b;
  logic [LT_W-1:0]   a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;
  logic              wa_en, wa_vld, wb_en, wb_vld;
  logic [LT_W-1:0]   wa_tag, wb_tag;
  logic [DATA_W-1:0] wa_data, wb_data;

  pac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pac_frame_store #(.IDX_W(IDX_W), .LT_W(LT_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_a_idx(prim_idx), .rd_a_vld(a_vld), .rd_a_tag(a_tag), .rd_a_data(a_data),
    .rd_b_idx(alt_idx), .rd_b_vld(b_vld), .rd_b_tag(b_tag), .rd_b_data(b_data),
    .wr_a_en(wa_en), .wr_a_idx(prim_idx), .wr_a_vld(wa_vld), .wr_a_tag(wa_tag),
    .wr_a_data(wa_data),
    .wr_b_en(wb_en), .wr_b_idx(alt_idx), .wr_b_vld(wb_vld), .wr_b_tag(wb_tag),
    .wr_b_data(wb_data)
  );

  pac_tag_match #(.LT_W(LT_W)) u_match_pri (
    .line_vld(a_vld), .line_tag(a_tag), .probe_tag(probe_tag), .hit(hit_a)
  );

  pac_tag_match #(.LT_W(LT_W)) u_match_alt (
    .line_vld(b_vld), .line_tag(b_tag), .probe_tag(probe_tag), .hit(hit_b)
  );

  pac_probe_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .OFF_W(OFF_W), .TAG_W(TAG_W), .LT_W(LT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .prim_idx(prim_idx), .alt_idx(alt_idx), .probe_tag(probe_tag),
    .hit_a(hit_a), .hit_b(hit_b),
    .a_vld(a_vld), .a_tag(a_tag), .a_data(a_data),
    .b_vld(b_vld), .b_tag(b_tag), .b_data(b_data),
    .wa_en(wa_en), .wa_vld(wa_vld), .wa_tag(wa_tag), .wa_data(wa_data),
    .wb_en(wb_en), .wb_vld(wb_vld), .wb_tag(wb_tag), .wb_data(wb_data)
  );

endmodule

// File: rtl/pac_cache_ctrl_chk.sv
module pac_cache_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_kind,
  input logic              mem_req_valid,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              mem_ack
);

  // R9: acceptance makes the controller busy on the next cycle
  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9: no new request can be taken during the response cycle
  assert_rsp_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R9: the response strobe lasts a single cycle
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3: no response in the cycle right after acceptance
  assert_no_early_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !rsp_valid);

  // R3: every response carries one of the three outcome codes
  assert_kind_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind != 2'd0));

  // R10: a memory request holds steady until acknowledged
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_ack) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R8: store data presented to memory stays fixed while waiting
  assert_wdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && !mem_ack) |=> $stable(mem_req_wdata));

  // R1: an idle controller drives neither a response nor a memory request
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !rsp_valid));

endmodule

bind pac_cache_ctrl pac_cache_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .mem_req_valid(mem_req_valid),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_ack(mem_ack)
);

// File: tb/sim_pac_cache_ctrl.sv
`timescale 1ns/1ps
module sim_pac_cache_ctrl;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int NVEC   = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [1:0]        rsp_kind;
  logic [DATA_W-1:0] rsp_rdata;
  logic              mem_req_valid;
  logic              mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_wdata;
  logic              mem_ack = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  int tests = 0;
  int fails = 0;
  int mem_wait = 0;
  int mem_cnt = 0;
  logic              last_w = 1'b0;
  logic [ADDR_W-1:0] last_addr = '0;
  logic [DATA_W-1:0] last_data = '0;

  always #4 clk = ~clk;  // 125 MHz

  pac_cache_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [DATA_W-1:0] mem_fn(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] al;
    al = {a[ADDR_W-1:2], 2'b00};
    return {al, al ^ 16'hA5C3};
  endfunction

  // Memory model: acknowledges on the second falling edge a request is seen
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack  = 1'b0;
      mem_wait = 0;
    end else if (mem_req_valid) begin
      if (mem_wait == 1) begin
        mem_ack   = 1'b1;
        mem_rdata = mem_fn(mem_req_addr);
        mem_cnt++;
        last_w    = mem_req_write;
        last_addr = mem_req_addr;
        last_data = mem_req_wdata;
      end else begin
        mem_wait++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic w, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] wd, output logic [1:0] kind,
                        output logic [DATA_W-1:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    kind = rsp_kind;
    rd   = rsp_rdata;
  endtask

  // {write, addr, wdata, kind, latency, expected data (0 = memory pattern)}
  localparam logic [86:0] VEC [NVEC] = '{
    {1'b0, 16'h0104, 32'h0,        2'd3, 4'd4, 32'h0},        // R1 cold miss, R10
    {1'b0, 16'h0106, 32'h0,        2'd1, 4'd1, 32'h0},        // R2 offset ignored, R3
    {1'b0, 16'h0204, 32'h0,        2'd3, 4'd4, 32'h0},        // R6 A moves to partner
    {1'b0, 16'h0104, 32'h0,        2'd2, 4'd2, 32'h0},        // R4 pseudo-hit, R5 swap
    {1'b0, 16'h0104, 32'h0,        2'd1, 4'd1, 32'h0},        // R5 now primary
    {1'b0, 16'h0204, 32'h0,        2'd2, 4'd2, 32'h0},        // R5 displaced line
    {1'b0, 16'h0114, 32'h0,        2'd3, 4'd4, 32'h0},        // R7 same tag, other MSB
    {1'b0, 16'h0204, 32'h0,        2'd3, 4'd4, 32'h0},        // R6 evicted line
    {1'b0, 16'h0104, 32'h0,        2'd2, 4'd2, 32'h0},        // R6 kept in partner
    {1'b1, 16'h0104, 32'hDEADBEEF, 2'd1, 4'd3, 32'h0},        // R8 store primary hit
    {1'b0, 16'h0104, 32'h0,        2'd1, 4'd1, 32'hDEADBEEF}, // R8 updated word
    {1'b1, 16'h0204, 32'h12345678, 2'd2, 4'd4, 32'h0},        // R8 store pseudo-hit
    {1'b0, 16'h0204, 32'h0,        2'd2, 4'd2, 32'h12345678}, // R8 no swap on store
    {1'b1, 16'h0304, 32'h0BADF00D, 2'd3, 4'd4, 32'h0},        // R8 store miss
    {1'b0, 16'h0304, 32'h0,        2'd3, 4'd4, 32'h0},        // R8 no allocate
    {1'b0, 16'h0204, 32'h0,        2'd2, 4'd2, 32'h12345678}, // R6 old primary kept
    {1'b0, 16'h0304, 32'h0,        2'd2, 4'd2, 32'h0},        // R5 swapped out
    {1'b0, 16'h0114, 32'h0,        2'd3, 4'd4, 32'h0},        // R7 still distinct
    {1'b0, 16'h0008, 32'h0,        2'd3, 4'd4, 32'h0},        // R10 other set
    {1'b0, 16'h000B, 32'h0,        2'd1, 4'd1, 32'h0}         // R2 top offset byte
  };

  initial begin : wdog
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [1:0]        kind;
    logic [DATA_W-1:0] rd;
    int                lat;
    int                m0;
    bit                busy_ok;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(req_ready === 1'b1, "R1 req_ready after reset", req_ready, 1);
    check(rsp_valid === 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    check(mem_req_valid === 1'b0, "R1 mem_req_valid after reset", mem_req_valid, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [86:0]       v;
      logic [DATA_W-1:0] exp_d;
      int                exp_m;
      v  = VEC[i];
      m0 = mem_cnt;
      do_req(v[86], v[85:70], v[69:38], kind, rd, lat);
      check(kind == v[37:36], $sformatf("R3 kind vec %0d", i), kind, v[37:36]);
      check(lat == int'(v[35:32]), $sformatf("R3 latency vec %0d", i), lat, v[35:32]);
      exp_m = (v[86] || v[37:36] == 2'd3) ? 1 : 0;
      check(mem_cnt - m0 == exp_m, $sformatf("R8 memory transfers vec %0d", i),
            mem_cnt - m0, exp_m);
      if (!v[86]) begin
        exp_d = (v[31:0] == 32'h0) ? mem_fn(v[85:70]) : v[31:0];
        check(rd == exp_d, $sformatf("R10 read data vec %0d", i), rd, exp_d);
      end else begin
        check(last_w && last_addr == v[85:70] && last_data == v[69:38],
              $sformatf("R8 write-through vec %0d", i), {last_w, last_addr, last_data},
              {1'b1, v[85:70], v[69:38]});
      end
    end

    // R9: requests while busy are ignored
    m0 = mem_cnt;
    busy_ok = 1'b1;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = 16'h0408;
    @(negedge clk);
    req_write = 1'b1;
    req_addr  = 16'h0104;
    req_wdata = 32'hFFFF0000;
    lat = 0;
    while (!rsp_valid && lat < 60) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    check(busy_ok && !req_ready, "R9 ready low while busy", req_ready, 0);
    check(rsp_kind == 2'd3 && rsp_rdata == mem_fn(16'h0408), "R9 first request served",
          rsp_rdata, mem_fn(16'h0408));
    req_valid = 1'b0;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R9 single-cycle response", {rsp_valid, req_ready}, 2'b01);
    check(mem_cnt - m0 == 1 && !last_w, "R9 busy request not issued", mem_cnt - m0, 1);

    // R1: reset in mid-run invalidates every frame
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R1 state after second reset",
          {req_ready, rsp_valid, mem_req_valid}, 3'b100);
    do_req(1'b0, 16'h0114, '0, kind, rd, lat);
    check(kind == 2'd3, "R1 cached line lost after reset", kind, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule